// File: doc/BRIEF.md
# Latched Edge Interrupt Aggregator

This block collects a set of edge-type interrupt sources (32 by default) and presents them to an upstream interrupt controller as one interrupt line. A rising edge on any source sets a sticky status bit, which stays set until software clears it. A per-source mask decides whether a latched bit contributes to the shared output. A mask bit of 1 disables its source, and every source starts masked.

Software reaches the block through a small register port. The port has read and write strobes, a 3-bit word index, and 32-bit data. Status and mask are not written directly. Each has a write-one-to-set word and a write-one-to-clear word, so one bit can be changed without a read-modify-write. Read data is registered and appears on the clock edge that samples the read strobe. The interrupt output is the registered OR of all unmasked latched bits.

Top module: `irq_latch_agg`

## Requirements
- R1: After reset, all status bits are 0 and all mask bits are 1. The interrupt output is 0 and the read data is 0.
- R2: A rising edge on a source sets its status bit on the next clock edge. The edge is found by comparing the input with a registered copy of it. That copy resets to all ones, so an input that is already high when reset is released does not latch.
- R3: A latched status bit stays 1, whatever the source level or mask, until software clears it.
- R4: Writing word 2 (byte offset 0x08) clears every status bit whose data bit is 1. Status bits written with 0 do not change.
- R5: If a source edge and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Writing word 1 (byte offset 0x04) sets every status bit whose data bit is 1. Status bits written with 0 do not change.
- R7: Writing word 4 (byte offset 0x10) sets mask bits where the data bit is 1. Writing word 5 (byte offset 0x14) clears mask bits where the data bit is 1. Mask bits written with 0 do not change.
- R8: A read of word 0 returns status, and a read of word 3 returns the mask, with 1 meaning masked. All other words read 0. Read data is updated on the edge where rd_en is sampled and holds between reads.
- R9: Writes to word 0, word 3, word 6 and word 7 change neither status nor mask.
- R10: irq_o equals the OR of (status AND NOT mask), as that value stood one clock earlier.
- R11: Masking a source does not clear its status bit. Unmasking a bit that is still latched raises irq_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Interrupt sources, edge sensitive |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word index of the register accessed |
| wdata | input | 32 | Write data, one bit per source |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregated interrupt to the upstream controller |

## Verification
The bench builds the block at its defaults: 32 sources and a 3-bit word index. At these values every data bit maps to a real source, and the two unused word indices can be exercised for R8 and R9. With all 32 lanes present, random source toggles regularly collide with clear writes on the same bit, which exercises the set-over-clear rule of R5. It also covers every combination of mask and status that drives irq_o.

// File: rtl/irq_latch_agg.sv
module irq_latch_agg #(
  parameter int N  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_SSET = AW'(1);
  localparam logic [AW-1:0] A_SCLR = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_MSET = AW'(4);
  localparam logic [AW-1:0] A_MCLR = AW'(5);

  logic [N-1:0] src_q, status, mask;
  logic [N-1:0] rise, wbits, pend;
  logic         sset, sclr, mset, mclr;
  logic [31:0]  rd_mux;

  assign wbits = wdata[N-1:0];
  assign rise  = src_i & ~src_q;
  assign pend  = status & ~mask;
  assign sset  = wr_en && (addr == A_SSET);
  assign sclr  = wr_en && (addr == A_SCLR);
  assign mset  = wr_en && (addr == A_MSET);
  assign mclr  = wr_en && (addr == A_MCLR);

  always_comb begin
    case (addr)
      A_STAT:  rd_mux = 32'(status);
      A_MASK:  rd_mux = 32'(mask);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '1;
      status <= '0;
      mask   <= '1;
      irq_o  <= 1'b0;
      rdata  <= '0;
    end else begin
      src_q  <= src_i;
      status <= (status & ~(sclr ? wbits : '0)) | (sset ? wbits : '0) | rise;
      mask   <= (mask | (mset ? wbits : '0)) & ~(mclr ? wbits : '0);
      irq_o  <= |pend;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclr |=> (($past(status) & ~status) == '0));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> ((status & $past(wbits & ~rise)) == '0));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr && |(rise & wbits)) |=> ((status & $past(rise & wbits)) == $past(rise & wbits)));

  assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sset |=> ((status & $past(wbits)) == $past(wbits)));

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mset |=> ((mask & $past(wbits)) == $past(wbits)));

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> ((mask & $past(wbits)) == '0));

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_STAT || addr == A_MASK || addr > A_MCLR))
      |=> ((status == ($past(status) | $past(rise))) && $stable(mask)));

  assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(status) != '0));

  assert_mask_keeps_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mset && !sclr) |=> (($past(status) & ~status) == '0));
endmodule

// File: tb/sim_irq_latch_agg.sv
module sim_irq_latch_agg;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_o;

  int checks = 0, fails = 0;
  logic [N-1:0] m_src = '1, m_stat = '0, m_mask = '1;
  logic [31:0] m_rdata = '0;
  logic m_irq = 1'b0;

  irq_latch_agg #(.N(N), .AW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(logic [2:0] a);
    if (a == 3'd0) return 32'(m_stat);
    if (a == 3'd3) return 32'(m_mask);
    return 32'd0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [N-1:0] s, bit rd, bit wr, logic [2:0] a,
                       logic [31:0] wd, string tag);
    logic [N-1:0] rise, ns, nm;
    logic [31:0] nr;
    logic ni;
    src_i = s; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    rise = s & ~m_src;
    ns = m_stat; nm = m_mask;
    if (wr && a == 3'd2) ns = ns & ~wd[N-1:0];
    if (wr && a == 3'd1) ns = ns | wd[N-1:0];
    ns = ns | rise;
    if (wr && a == 3'd4) nm = nm | wd[N-1:0];
    if (wr && a == 3'd5) nm = nm & ~wd[N-1:0];
    ni = |(m_stat & ~m_mask);
    nr = rd ? model_read(a) : m_rdata;
    @(posedge clk);
    m_src = s; m_stat = ns; m_mask = nm; m_irq = ni; m_rdata = nr;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(irq_o === m_irq, "R10 irq_o", 32'(irq_o), 32'(m_irq));
    if (rd) check(rdata === m_rdata, tag, rdata, m_rdata);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    cycle(src_i, 1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cycle(src_i, 1'b0, 1'b1, a, d, "R8 read");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    src_i = 32'h0000_0080;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_src = '1;
    check(irq_o === 1'b0, "R1 irq after reset", 32'(irq_o), 32'd0);
    check(rdata === 32'd0, "R1 rdata after reset", rdata, 32'd0);
    rd(3'd0, "R1 status after reset (R2 high-at-reset not latched)");
    check(rdata === 32'd0, "R2 input high at reset release", rdata, 32'd0);
    rd(3'd3, "R1 mask after reset");

    cycle(32'h0000_0088, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
    cycle(32'h0000_0000, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
    rd(3'd0, "R2 edge latched while masked, R3 held after input fell");
    check(rdata === 32'h0000_0008, "R3 sticky bit", rdata, 32'h8);
    wr(3'd5, 32'h0000_0008);
    cycle(src_i, 1'b0, 1'b0, 3'd0, 32'd0, "R10");
    check(irq_o === 1'b1, "R10 irq after unmask", 32'(irq_o), 32'd1);
    wr(3'd4, 32'h0000_0008);
    cycle(src_i, 1'b0, 1'b0, 3'd0, 32'd0, "R11");
    check(irq_o === 1'b0, "R11 irq low when masked", 32'(irq_o), 32'd0);
    rd(3'd0, "R11 status kept while masked");
    wr(3'd5, 32'h0000_0008);
    cycle(src_i, 1'b0, 1'b0, 3'd0, 32'd0, "R11");
    check(irq_o === 1'b1, "R11 irq back after unmask", 32'(irq_o), 32'd1);
    rd(3'd3, "R7 mask readback");
    wr(3'd2, 32'h0000_0000);
    rd(3'd0, "R4 zero bits leave status");
    wr(3'd2, 32'h0000_0008);
    rd(3'd0, "R4 status cleared");
    cycle(32'h0000_0020, 1'b0, 1'b1, 3'd2, 32'h0000_0020, "R5");
    rd(3'd0, "R5 edge beats clear");
    wr(3'd1, 32'h8000_0001);
    rd(3'd0, "R6 forced bits");
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_0000);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    rd(3'd0, "R9 status after ignored writes");
    rd(3'd3, "R9 mask after ignored writes");
    rd(3'd1, "R8 set word reads 0");
    rd(3'd2, "R8 clear word reads 0");
    rd(3'd4, "R8 mask-set word reads 0");
    rd(3'd5, "R8 mask-clear word reads 0");
    rd(3'd6, "R8 unused word reads 0");

    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] s;
      logic [2:0] a;
      logic [31:0] d;
      bit r, w;
      s = src_i ^ ($urandom & $urandom & $urandom);
      a = 3'($urandom);
      d = $urandom & $urandom;
      r = ($urandom % 3) == 0;
      w = ($urandom % 2) == 0;
      cycle(s, r, w, a, d, "R8 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule